// File: doc/BRIEF.md
# Graphics Command Packet Framer

The framer sits between a 32-bit command word stream and a drawing back end. It reads the opcode from the top byte of each leading word and works out how many words belong to that command. Most commands have a fixed length. Polyline commands have a variable length and end at a terminator word. The framer gathers every word of a command before it forwards any of them. It then sends the whole packet downstream as a framed burst with first and last markers.

Three command groups stay inside the block and are not forwarded:

- **Environment-setting words** are written into an eight-entry register bank. A status word mirrors selected bits of that bank.
- **Image-transfer commands** are decoded into a rectangle (position, width, height) and announced to a transfer engine with a one-cycle start pulse.
- **Unknown or zero-length opcodes** are dropped.

After a write transfer is announced, the framer becomes a pipe. The number of input words needed to cover the rectangle's 16-bit pixels is sent straight to the engine's data port without decoding. Command decoding resumes after the last of those words.

Top module: `cmd_packet_framer`

## Requirements
- R1: The opcode is bits 31:24 of a packet's first word, and a fixed-length packet has one word plus a per-opcode parameter count. Examples: 0x20 gives 3, 0x28 gives 4, 0x2C gives 8, 0x3C gives 11, 0x02 gives 2 and 0x68 gives 1. The packet is forwarded unchanged and in arrival order.
- R2: No word of a packet appears at the output until its last word has been accepted. Partial packets survive any number of idle input cycles. `in_ready` is low while a packet is being emitted.
- R3: Output words carry `pkt_first` on the first word and `pkt_last` on the final word. While `pkt_valid` is high and `pkt_ready` is low, the data and markers hold steady.
- R4: A word with opcode 0xE0–0xE7 replaces environment register (opcode & 7) with the full 32-bit word and is not forwarded. Register i occupies bits 32*i+31:32*i of `env_regs`.
- R5: After reset, environment register i reads (0xE0+i) in bits 31:24 and zero below. The status word is zero, `in_ready` is high and `pkt_valid` is low.
- R6: One cycle after an environment register changes, `status[10:0]` equals register 1 bits 10:0 and `status[12:11]` equals register 6 bits 1:0.
- R7: Opcodes 0x48–0x4F are flat polylines. Each ends at the first word with index 3 or more (index 0 is the opcode word) for which (word & 0xF000F000) == 0x50005000. Opcodes 0x58–0x5F are shaded polylines and only test even indices of 4 or more. The terminator is part of the packet.
- R8: A polyline that has not terminated is closed when it reaches PKT_DEPTH words. The next word is decoded as a new command.
- R9: Opcodes 0xA0–0xDF take three words: command, position and size. They produce one `xfer_start` pulse and are not forwarded. x is position bits 9:0 and y is position bits 24:16. Width is size bits 9:0 and height is size bits 24:16, where a zero field means the maximum (1024 or 512). `xfer_read` is set for opcodes 0xC0–0xDF.
- R10: After a write transfer starts, the next ceil(width*height/2) input words go to `xfer_wr_data` undecoded, and `in_ready` follows `xfer_wr_ready` during that phase. None of those words changes the environment registers or the packet output.
- R11: An opcode outside the transfer and environment ranges whose parameter count is zero (for example 0x00, 0x6C, 0x81) is consumed as one word and dropped.
- R12: A read transfer (0xC0–0xDF) has no data phase, and the very next word is decoded as a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Framer accepts the input word |
| in_data | input | 32 | Command or pixel data word |
| pkt_valid | output | 1 | Packet word available |
| pkt_ready | input | 1 | Downstream accepts the packet word |
| pkt_data | output | 32 | Packet word |
| pkt_first | output | 1 | Marks the opcode word of a packet |
| pkt_last | output | 1 | Marks the final word of a packet |
| xfer_start | output | 1 | One-cycle pulse announcing a rectangle transfer |
| xfer_read | output | 1 | Announced transfer reads pixel memory |
| xfer_x | output | XW | Rectangle left column |
| xfer_y | output | YW | Rectangle top row |
| xfer_w | output | XW+1 | Rectangle width in pixels |
| xfer_h | output | YW+1 | Rectangle height in rows |
| xfer_wr_valid | output | 1 | Pixel data word valid toward the transfer engine |
| xfer_wr_ready | input | 1 | Transfer engine accepts a data word |
| xfer_wr_data | output | 32 | Pixel data word, two 16-bit pixels |
| env_regs | output | 256 | Eight environment registers, register i at bits 32*i+31:32*i |
| status | output | 13 | Mirrored environment status bits |

## Verification
The hardest states to reach from the ports are the ones where a word looks like something it is not. Examples are a polyline terminator pattern at an index that must not end the packet, and an environment opcode arriving as pixel data inside a write transfer. The stimulus places such words on purpose. It puts a terminator pattern at index 2 of a flat line and at odd indices of a shaded line. It also sends 0xE1FFFFFF as the first data word of a transfer, then reads the environment bank back to show it was untouched. A transfer with a zero height field pushes 256 data words through while `xfer_wr_ready` stalls periodically. This covers the maximum-size decode and a long data phase under back-pressure.

// File: rtl/gcpf_pkg.sv
package gcpf_pkg;

   localparam int WORD_W = 32;
   localparam int ENV_N  = 8;
   localparam int STAT_W = 13;

   typedef enum logic [1:0] {
      K_FIXED,
      K_LINE_FLAT,
      K_LINE_SHADED,
      K_XFER
   } pkt_kind_e;

   typedef enum logic [1:0] {
      ST_COLLECT,
      ST_EMIT,
      ST_XFER
   } fr_state_e;

   // parameter words that follow an opcode word (zero: single word)
   function automatic logic [3:0] param_words(input logic [7:0] op);
      logic [3:0] n;
      n = 4'd0;
      case (op[7:4])
         4'h0: n = (op == 8'h02) ? 4'd2 : 4'd0;
         4'h2: case (op[3:2])
                  2'd0: n = 4'd3;
                  2'd1: n = 4'd6;
                  2'd2: n = 4'd4;
                  default: n = 4'd8;
               endcase
         4'h3: case (op[3:2])
                  2'd0: n = 4'd5;
                  2'd1: n = 4'd8;
                  2'd2: n = 4'd7;
                  default: n = 4'd11;
               endcase
         4'h4: n = op[3] ? 4'd3 : 4'd2;
         4'h5: n = op[3] ? 4'd4 : 4'd3;
         4'h6: case (op[3:2])
                  2'd0: n = 4'd2;
                  2'd1: n = 4'd3;
                  2'd2: n = 4'd1;
                  default: n = 4'd0;
               endcase
         4'h7: n = op[2] ? 4'd2 : 4'd1;
         4'h8: n = (op == 8'h80) ? 4'd3 : 4'd0;
         default: n = 4'd0;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/gcpf_op_decode.sv
module gcpf_op_decode
   import gcpf_pkg::*;
(
   input  logic [7:0] op_i,
   output pkt_kind_e  kind_o,
   output logic [3:0] len_o,
   output logic       env_o,
   output logic       drop_o,
   output logic       read_o
);

   logic is_xfer;
   logic is_flat;
   logic is_shaded;

   always_comb begin
      is_xfer   = (op_i[7:5] == 3'b101) || (op_i[7:5] == 3'b110);
      is_flat   = (op_i[7:3] == 5'b01001);
      is_shaded = (op_i[7:3] == 5'b01011);
      env_o     = (op_i[7:3] == 5'b11100);
      read_o    = (op_i[7:5] == 3'b110);
      len_o     = param_words(op_i);
      if (is_xfer)        kind_o = K_XFER;
      else if (is_flat)   kind_o = K_LINE_FLAT;
      else if (is_shaded) kind_o = K_LINE_SHADED;
      else                kind_o = K_FIXED;
      drop_o = !is_xfer && !env_o && (len_o == 4'd0);
   end

endmodule

// File: rtl/gcpf_env_bank.sv
module gcpf_env_bank
   import gcpf_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we_i,
   input  logic [$clog2(ENV_N)-1:0]  idx_i,
   input  logic [WORD_W-1:0]         wdata_i,
   output logic [ENV_N*WORD_W-1:0]   env_o,
   output logic [STAT_W-1:0]         stat_o
);

   logic [WORD_W-1:0] env_q [ENV_N];

   generate
      for (genvar i = 0; i < ENV_N; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               env_q[i] <= {8'(224 + i), {(WORD_W-8){1'b0}}};
            else if (we_i && (idx_i == i))
               env_q[i] <= wdata_i;
         end
         assign env_o[i*WORD_W +: WORD_W] = env_q[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_o <= '0;
      else        stat_o <= {env_q[6][1:0], env_q[1][10:0]};
   end

   assert_env_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (env_o[$past(idx_i)*WORD_W +: WORD_W] == $past(wdata_i)));

   assert_status_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && idx_i == 1) ##1 !(we_i && idx_i == 1) |=> stat_o[10:0] == $past(wdata_i[10:0], 2));

endmodule

// File: rtl/gcpf_xfer_track.sv
module gcpf_xfer_track #(
   parameter int XW = 10,
   parameter int YW = 9
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          read_i,
   input  logic [XW-1:0] xf_i,
   input  logic [YW-1:0] yf_i,
   input  logic [XW-1:0] wf_i,
   input  logic [YW-1:0] hf_i,
   input  logic          beat_i,
   output logic          start_o,
   output logic          read_o,
   output logic [XW-1:0] x_o,
   output logic [YW-1:0] y_o,
   output logic [XW:0]   w_o,
   output logic [YW:0]   h_o,
   output logic          busy_o,
   output logic          last_o
);

   localparam int WW   = XW + 1;
   localparam int HW   = YW + 1;
   localparam int PW   = WW + HW;
   localparam int CNTW = XW + YW;

   logic [WW-1:0]   w_dec;
   logic [HW-1:0]   h_dec;
   logic [PW-1:0]   prod;
   logic [CNTW-1:0] words;
   logic [CNTW-1:0] cnt_q;

   always_comb begin
      w_dec = (wf_i == '0) ? (WW'(1) << XW) : {1'b0, wf_i};
      h_dec = (hf_i == '0) ? (HW'(1) << YW) : {1'b0, hf_i};
      prod  = PW'(w_dec) * PW'(h_dec);
      words = CNTW'((prod + PW'(1)) >> 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_o <= 1'b0;
         read_o  <= 1'b0;
         x_o     <= '0;
         y_o     <= '0;
         w_o     <= '0;
         h_o     <= '0;
         cnt_q   <= '0;
      end else begin
         start_o <= start_i;
         if (start_i) begin
            read_o <= read_i;
            x_o    <= xf_i;
            y_o    <= yf_i;
            w_o    <= w_dec;
            h_o    <= h_dec;
            if (!read_i) cnt_q <= words;
         end else if (beat_i && cnt_q != '0) begin
            cnt_q <= cnt_q - CNTW'(1);
         end
      end
   end

   assign busy_o = (cnt_q != '0);
   assign last_o = beat_i && (cnt_q == CNTW'(1));

   assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);

   assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_i && busy_o && !start_i) |=> cnt_q == $past(cnt_q) - CNTW'(1));

endmodule

// File: rtl/cmd_packet_framer.sv
module cmd_packet_framer
   import gcpf_pkg::*;
#(
   parameter int PKT_DEPTH = 16,
   parameter int XW        = 10,
   parameter int YW        = 9
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [WORD_W-1:0]         in_data,
   output logic                      pkt_valid,
   input  logic                      pkt_ready,
   output logic [WORD_W-1:0]         pkt_data,
   output logic                      pkt_first,
   output logic                      pkt_last,
   output logic                      xfer_start,
   output logic                      xfer_read,
   output logic [XW-1:0]             xfer_x,
   output logic [YW-1:0]             xfer_y,
   output logic [XW:0]               xfer_w,
   output logic [YW:0]               xfer_h,
   output logic                      xfer_wr_valid,
   input  logic                      xfer_wr_ready,
   output logic [WORD_W-1:0]         xfer_wr_data,
   output logic [ENV_N*WORD_W-1:0]   env_regs,
   output logic [STAT_W-1:0]         status
);

   localparam int CW = $clog2(PKT_DEPTH + 1);
   localparam int RW = $clog2(PKT_DEPTH);

   generate
      if (PKT_DEPTH < 12) begin : g_bad_depth
         initial $error("PKT_DEPTH must hold the longest fixed packet (12 words)");
      end
      if (XW > 16 || YW > 16) begin : g_bad_field
         initial $error("XW and YW must fit a 16-bit half word");
      end
   endgenerate

   fr_state_e        state;
   pkt_kind_e        kind_r;
   pkt_kind_e        dec_kind;
   logic [3:0]       dec_len;
   logic             dec_env, dec_drop, dec_read;
   logic [CW-1:0]    wcnt, need_r;
   logic [RW-1:0]    rd;
   logic             rd_flag_r;
   logic [WORD_W-1:0] pbuf [PKT_DEPTH];

   logic             term, full, pkt_done, store, env_we, xfer_go, beat, last_beat;
   logic             trk_busy, trk_last;

   gcpf_op_decode u_dec (
      .op_i   (in_data[31:24]),
      .kind_o (dec_kind),
      .len_o  (dec_len),
      .env_o  (dec_env),
      .drop_o (dec_drop),
      .read_o (dec_read)
   );

   gcpf_env_bank u_env (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (env_we),
      .idx_i   (in_data[26:24]),
      .wdata_i (in_data),
      .env_o   (env_regs),
      .stat_o  (status)
   );

   gcpf_xfer_track #(.XW(XW), .YW(YW)) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (xfer_go),
      .read_i  (rd_flag_r),
      .xf_i    (pbuf[1][XW-1:0]),
      .yf_i    (pbuf[1][16 +: YW]),
      .wf_i    (in_data[XW-1:0]),
      .hf_i    (in_data[16 +: YW]),
      .beat_i  (beat),
      .start_o (xfer_start),
      .read_o  (xfer_read),
      .x_o     (xfer_x),
      .y_o     (xfer_y),
      .w_o     (xfer_w),
      .h_o     (xfer_h),
      .busy_o  (trk_busy),
      .last_o  (trk_last)
   );

   always_comb begin
      term = ((in_data & 32'hF000_F000) == 32'h5000_5000);
      full = (wcnt == CW'(PKT_DEPTH - 1));
      case (kind_r)
         K_FIXED:       pkt_done = (wcnt + CW'(1) == need_r);
         K_LINE_FLAT:   pkt_done = ((wcnt >= CW'(3)) && term) || full;
         K_LINE_SHADED: pkt_done = ((wcnt >= CW'(4)) && !wcnt[0] && term) || full;
         default:       pkt_done = (wcnt == CW'(2));
      endcase
   end

   assign in_ready      = (state == ST_COLLECT) || ((state == ST_XFER) && xfer_wr_ready);
   assign store         = (state == ST_COLLECT) && in_valid &&
                          ((wcnt != '0) || (!dec_env && !dec_drop));
   assign env_we        = (state == ST_COLLECT) && in_valid && (wcnt == '0) && dec_env;
   assign xfer_go       = (state == ST_COLLECT) && in_valid && (wcnt != '0) &&
                          (kind_r == K_XFER) && pkt_done;
   assign beat          = (state == ST_XFER) && in_valid && xfer_wr_ready;
   assign xfer_wr_valid = (state == ST_XFER) && in_valid;
   assign xfer_wr_data  = in_data;

   assign pkt_valid = (state == ST_EMIT);
   assign pkt_data  = pbuf[rd];
   assign last_beat = (CW'(rd) == wcnt - CW'(1));
   assign pkt_first = pkt_valid && (rd == '0);
   assign pkt_last  = pkt_valid && last_beat;

   always_ff @(posedge clk) begin
      if (store) pbuf[RW'(wcnt)] <= in_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_COLLECT;
         kind_r    <= K_FIXED;
         wcnt      <= '0;
         need_r    <= '0;
         rd        <= '0;
         rd_flag_r <= 1'b0;
      end else begin
         case (state)
            ST_COLLECT: if (in_valid) begin
               if (wcnt == '0) begin
                  if (!dec_env && !dec_drop) begin
                     kind_r    <= dec_kind;
                     need_r    <= CW'(dec_len) + CW'(1);
                     rd_flag_r <= dec_read;
                     wcnt      <= CW'(1);
                  end
               end else if (pkt_done) begin
                  if (kind_r == K_XFER) begin
                     wcnt <= '0;
                     if (!rd_flag_r) state <= ST_XFER;
                  end else begin
                     wcnt  <= wcnt + CW'(1);
                     rd    <= '0;
                     state <= ST_EMIT;
                  end
               end else begin
                  wcnt <= wcnt + CW'(1);
               end
            end
            ST_EMIT: if (pkt_ready) begin
               if (last_beat) begin
                  state <= ST_COLLECT;
                  wcnt  <= '0;
                  rd    <= '0;
               end else begin
                  rd <= rd + RW'(1);
               end
            end
            ST_XFER: if (trk_last) state <= ST_COLLECT;
            default: state <= ST_COLLECT;
         endcase
      end
   end

   assert_hold_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !pkt_ready) |=> pkt_valid && $stable(pkt_data) && $stable(pkt_last));

   assert_no_input_emit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> !in_ready);

   assert_xfer_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_wr_valid |-> (trk_busy && !pkt_valid));

   assert_read_no_phase_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_start && xfer_read) |-> !xfer_wr_valid);

endmodule

// File: tb/sim_cmd_packet_framer.sv
module sim_cmd_packet_framer;

   localparam int DEPTH = 16;
   localparam int XW    = 10;
   localparam int YW    = 9;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst_n;
   logic              in_valid, in_ready;
   logic [31:0]       in_data;
   logic              pkt_valid, pkt_ready, pkt_first, pkt_last;
   logic [31:0]       pkt_data;
   logic              xfer_start, xfer_read;
   logic [XW-1:0]     xfer_x;
   logic [YW-1:0]     xfer_y;
   logic [XW:0]       xfer_w;
   logic [YW:0]       xfer_h;
   logic              xfer_wr_valid, xfer_wr_ready;
   logic [31:0]       xfer_wr_data;
   logic [255:0]      env_regs;
   logic [12:0]       status;

   cmd_packet_framer #(.PKT_DEPTH(DEPTH), .XW(XW), .YW(YW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
      .pkt_first(pkt_first), .pkt_last(pkt_last),
      .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_x(xfer_x),
      .xfer_y(xfer_y), .xfer_w(xfer_w), .xfer_h(xfer_h),
      .xfer_wr_valid(xfer_wr_valid), .xfer_wr_ready(xfer_wr_ready),
      .xfer_wr_data(xfer_wr_data), .env_regs(env_regs), .status(status)
   );

   int    checks = 0;
   int    fails  = 0;
   bit    finished = 0;
   string cur_req = "R1";

   logic [33:0] pq[$];
   logic [40:0] xq[$];
   logic [31:0] dq[$];
   logic [31:0] cur[$];

   logic        held = 1'b0;
   logic [33:0] held_v;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [40:0] xt(input bit r, input int x, input int y, input int w, input int h);
      return {r, 10'(x), 9'(y), 11'(w), 10'(h)};
   endfunction

   // ready generators, change just after the clock edge
   int rc = 0;
   initial begin
      pkt_ready = 1'b0;
      xfer_wr_ready = 1'b0;
      forever begin
         @(posedge clk); #1;
         rc++;
         pkt_ready     = (rc % 3) != 0;
         xfer_wr_ready = (rc % 5) != 2;
      end
   end

   // monitor: sample at the falling edge, compare against the queues
   always @(negedge clk) begin
      if (rst_n) begin
         if (pkt_valid) check(!in_ready, "R2 in_ready while emitting", 64'(in_ready), 64'(0));
         if (held) check({pkt_first, pkt_last, pkt_data} == held_v && pkt_valid,
                         "R3 output held under back-pressure", 64'({pkt_first, pkt_last, pkt_data}), 64'(held_v));
         held   = pkt_valid && !pkt_ready;
         held_v = {pkt_first, pkt_last, pkt_data};
         if (pkt_valid && pkt_ready) begin
            if (pq.size() == 0) check(1'b0, {cur_req, " unexpected packet word"}, 64'(pkt_data), 64'(0));
            else begin
               logic [33:0] e;
               e = pq.pop_front();
               check({pkt_first, pkt_last, pkt_data} == e, {cur_req, " packet word"},
                     64'({pkt_first, pkt_last, pkt_data}), 64'(e));
            end
         end
         if (xfer_start) begin
            if (xq.size() == 0) check(1'b0, "R9 unexpected transfer start", 64'(xfer_x), 64'(0));
            else begin
               logic [40:0] e;
               e = xq.pop_front();
               check({xfer_read, xfer_x, xfer_y, xfer_w, xfer_h} == e, "R9 transfer rectangle",
                     64'({xfer_read, xfer_x, xfer_y, xfer_w, xfer_h}), 64'(e));
            end
         end
         if (xfer_wr_valid && xfer_wr_ready) begin
            if (dq.size() == 0) check(1'b0, "R10 unexpected data word", 64'(xfer_wr_data), 64'(0));
            else begin
               logic [31:0] e;
               e = dq.pop_front();
               check(xfer_wr_data == e, "R10 data word", 64'(xfer_wr_data), 64'(e));
            end
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send(input logic [31:0] w);
      in_valid = 1'b1;
      in_data  = w;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic emit_cur();
      for (int i = 0; i < cur.size(); i++)
         pq.push_back({i == 0, i == cur.size() - 1, cur[i]});
      for (int i = 0; i < cur.size(); i++) send(cur[i]);
   endtask

   task automatic fixed_pkt(input logic [7:0] op, input int n);
      cur.delete();
      for (int i = 0; i < n; i++)
         cur.push_back(i == 0 ? {op, 24'h00A5C3 + 24'(i)} : 32'h0101_0101 * i);
      emit_cur();
   endtask

   task automatic xfer(input logic [31:0] cmd, input logic [31:0] pos, input logic [31:0] size,
                       input logic [40:0] exp, input int ndata, input logic [31:0] first_d);
      xq.push_back(exp);
      send(cmd);
      send(pos);
      send(size);
      for (int i = 0; i < ndata; i++) begin
         logic [31:0] d;
         d = (i == 0) ? first_d : 32'hD000_0000 + 32'(i);
         dq.push_back(d);
         send(d);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog R2 actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      in_valid = 1'b0;
      in_data = '0;
      idle(4);
      rst_n = 1'b1;
      idle(1);

      // R5 reset state
      check(in_ready == 1'b1 && pkt_valid == 1'b0, "R5 handshake after reset", 64'({in_ready, pkt_valid}), 64'(2'b10));
      check(status == '0, "R5 status after reset", 64'(status), 64'(0));
      for (int i = 0; i < 8; i++)
         check(env_regs[i*32 +: 32] == {8'(224 + i), 24'h0}, "R5 env register reset",
               64'(env_regs[i*32 +: 32]), 64'({8'(224 + i), 24'h0}));

      // R1 fixed lengths
      cur_req = "R1";
      fixed_pkt(8'h20, 4);
      fixed_pkt(8'h2C, 9);
      fixed_pkt(8'h3C, 12);
      fixed_pkt(8'h02, 3);
      fixed_pkt(8'h68, 2);

      // R2 partial packet across idle input
      cur_req = "R2";
      cur.delete();
      for (int i = 0; i < 5; i++) cur.push_back(i == 0 ? 32'h2877_6655 : 32'h0A0B_0000 + 32'(i));
      for (int i = 0; i < 5; i++) pq.push_back({i == 0, i == 4, cur[i]});
      for (int i = 0; i < 3; i++) send(cur[i]);
      idle(6);
      check(pkt_valid == 1'b0 && in_ready == 1'b1, "R2 no output while incomplete",
            64'({pkt_valid, in_ready}), 64'(2'b01));
      send(cur[3]);
      send(cur[4]);

      // R4 / R6 environment bank and status mirror
      cur_req = "R4";
      send(32'hE100_0ABC);
      send(32'hE600_0003);
      send(32'hE5AB_CDEF);
      idle(3);
      check(env_regs[1*32 +: 32] == 32'hE100_0ABC, "R4 env register 1", 64'(env_regs[1*32 +: 32]), 64'h0E1000ABC);
      check(env_regs[6*32 +: 32] == 32'hE600_0003, "R4 env register 6", 64'(env_regs[6*32 +: 32]), 64'h0E6000003);
      check(env_regs[5*32 +: 32] == 32'hE5AB_CDEF, "R4 env register 5", 64'(env_regs[5*32 +: 32]), 64'h0E5ABCDEF);
      check(status == {2'b11, 11'h2BC}, "R6 status mirror", 64'(status), 64'({2'b11, 11'h2BC}));

      // R7 polylines
      cur_req = "R7";
      cur.delete();
      cur.push_back(32'h48AA_BBCC);
      cur.push_back(32'h0010_0010);
      cur.push_back(32'h5500_5000);   // matches at index 2: not a terminator
      cur.push_back(32'h0030_0030);
      cur.push_back(32'h5AB0_5CD0);   // index 4 ends the packet
      emit_cur();
      cur.delete();
      cur.push_back(32'h5811_2233);
      cur.push_back(32'h0001_0001);
      cur.push_back(32'h0001_0002);
      cur.push_back(32'h5000_5000);   // odd index: ignored
      cur.push_back(32'h0002_0002);
      cur.push_back(32'h5FFF_5FFF);   // odd index: ignored
      cur.push_back(32'h5123_5456);   // index 6 ends the packet
      emit_cur();
      fixed_pkt(8'h20, 4);

      // R8 forced close at DEPTH words
      cur_req = "R8";
      cur.delete();
      cur.push_back(32'h4A00_0000);
      for (int i = 1; i < DEPTH; i++) cur.push_back(32'(i));
      emit_cur();
      fixed_pkt(8'h02, 3);

      // R11 dropped opcodes
      cur_req = "R11";
      send(32'h0000_0000);
      send(32'h6C12_3456);
      send(32'h8100_0001);
      fixed_pkt(8'h02, 3);

      // R9 / R10 write transfers
      cur_req = "R10";
      xfer(32'hA000_0000, 32'h0010_0020, 32'h0002_0003, xt(0, 32, 16, 3, 2), 3, 32'hE1FF_FFFF);
      fixed_pkt(8'h20, 4);
      idle(3);
      check(env_regs[1*32 +: 32] == 32'hE100_0ABC, "R10 data word left env untouched",
            64'(env_regs[1*32 +: 32]), 64'h0E1000ABC);
      check(status == {2'b11, 11'h2BC}, "R10 status untouched", 64'(status), 64'({2'b11, 11'h2BC}));
      cur_req = "R9";
      xfer(32'hBF00_0000, 32'h01FF_03FF, 32'h0001_0003, xt(0, 1023, 511, 3, 1), 2, 32'hD000_0000);
      xfer(32'hA100_0000, 32'h0000_0000, 32'h0000_0001, xt(0, 0, 0, 1, 512), 256, 32'h2000_0000);

      // R12 read transfer, no data phase
      cur_req = "R12";
      xfer(32'hC500_0000, 32'h0005_0006, 32'h0004_0004, xt(1, 6, 5, 4, 4), 0, 32'h0);
      fixed_pkt(8'h20, 4);

      for (int k = 0; k < 4000 && (pq.size() != 0 || xq.size() != 0 || dq.size() != 0); k++)
         @(posedge clk);
      idle(2);
      check(pq.size() == 0, "R1 all packet words delivered", 64'(pq.size()), 64'(0));
      check(xq.size() == 0, "R9 all transfer starts seen", 64'(xq.size()), 64'(0));
      check(dq.size() == 0, "R10 all data words delivered", 64'(dq.size()), 64'(0));

      finished = 1;
      summary();
      $finish;
   end

endmodule